// File: doc/BRIEF.md
# Descriptor-Chained Endpoint IN DMA Channel

This block is one DMA channel that carries a buffer from system memory into the packet buffer of a USB device endpoint, for bulk, interrupt or isochronous IN traffic. Software programs a buffer address and a control word, or points the channel at a chain of descriptors in memory. The channel reads 32-bit words through a simple request/acknowledge read port and writes them into the endpoint buffer. It waits while the endpoint reports that no bank is free.

Packets are marked ready for transmission by hardware. A write that fills a packet validates it when the endpoint's automatic validation is on. The last write of a buffer validates whatever is left when the control word asks for validation at the end of the buffer. When a buffer is finished, the channel either stops and clears its enable, or fetches the next descriptor and carries on. An enabled endpoint interrupt can abort the channel at a word boundary. The channel raises an interrupt line when it records an end-of-buffer or an abort in its status word.

Top module: `ep_dma_chan`

## Requirements
- R1: Synchronous active-high reset clears all four registers, `mem_req`, `ep_wr`, `ep_valid` and `irq`, and leaves the channel idle.
- R2: Registers are selected by `reg_addr`: 0 next-descriptor pointer, 1 buffer address, 2 control, 3 status (read-only). `reg_rdata` shows the register selected in the previous cycle. A control write made while `ep_is_ctrl` is high stores every field but forces the enable bit to 0, and no memory request follows.
- R3: Control bit 0 is enable, bits 31:16 are the byte count. With enable set and load-next (bit 1) clear, the channel reads words in ascending order from the buffer address, with bits 1:0 ignored. It writes each word unchanged to `ep_wdata`, byte k on bits 8k+7:8k. `mem_req` stays high until `mem_ack`, and there is no request while the channel is idle.
- R4: Each write carries `ep_be` = 4'b1111, except a final word holding 1, 2 or 3 bytes, which carries 4'b0001, 4'b0011 or 4'b0111.
- R5: `ep_wr` is never high in the cycle after a clock edge at which `bank_full` was high. Stalled data is neither lost nor repeated.
- R6: When `ep_auto_valid` is high, the write that brings the packet fill to `PKT_BYTES` also raises `ep_valid`.
- R7: When control bit 3 (end-validate) is set, the last write of each buffer raises `ep_valid`. `ep_valid` is never high without `ep_wr`.
- R8: With load-next set, the channel reads three words from the next-descriptor pointer, with bits 3:0 forced to 0. The words are: next pointer, buffer address, control. It loads them into the registers and runs the loaded control word. The pointer register reads back with bits 3:0 cleared.
- R9: When the count reaches zero with load-next clear, the channel clears enable and goes idle with remaining count 0. If control bit 2 is set, it sets status bit 1 (end of buffer) and raises `irq`.
- R10: With control bit 4 set and `ep_irq` high at a word boundary, the channel sends no further word. It clears enable, sets status bit 2 (aborted), writes the unsent byte count into status bits 31:16, and raises `irq`.
- R11: Register writes made while the channel is busy (status bit 0) are ignored.
- R12: A control write while idle clears status bits 1 and 2 and drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ep_is_ctrl | input | 1 | Attached endpoint is a control endpoint |
| ep_auto_valid | input | 1 | Endpoint automatic packet validation enabled |
| ep_irq | input | 1 | Enabled endpoint interrupt pending |
| bank_full | input | 1 | Endpoint has no free bank |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Memory read word address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ep_wr | output | 1 | Endpoint buffer write |
| ep_wdata | output | 32 | Endpoint write data |
| ep_be | output | 4 | Endpoint byte enables |
| ep_valid | output | 1 | Packet ready for transmission |
| irq | output | 1 | Channel interrupt |

## Verification
The bench goes after buffers that end on 1 to 3 bytes. A design that got this wrong would send stale lanes or leave the short packet unvalidated. A random bank-full pattern catches a channel that drops or repeats a word while stalled. An abort timed to land on an exact word boundary exposes a channel that sends one word too many or reports the wrong remaining count. A two-descriptor chain with unaligned pointers shows whether low address bits leak into the fetch, or whether the channel stops after the first buffer. Control writes made while busy, or made against a control endpoint, must leave no trace in the transfer or the registers.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;
  localparam int DATA_W  = 32;
  localparam int BE_W    = DATA_W / 8;
  localparam int BEAT_BW = $clog2(BE_W + 1);
  localparam int CNT_W   = 16;

  localparam logic [1:0] REG_NEXT = 2'd0;
  localparam logic [1:0] REG_BUF  = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_BEAT,
    S_READ,
    S_WRITE
  } state_e;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic [10:0]      rsv;
    logic             irq_stop;
    logic             end_valid;
    logic             eob_ie;
    logic             load_next;
    logic             enable;
  } ctrl_t;
endpackage

// File: rtl/ep_dma_beat.sv
module ep_dma_beat
  import ep_dma_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic [CW-1:0]      count,
  output logic [BEAT_BW-1:0] beat_bytes,
  output logic [BE_W-1:0]    be
);
  for (genvar k = 0; k < BE_W; k++) begin : g_lane
    assign be[k] = count > CW'(k);
  end

  assign beat_bytes = (count >= CW'(BE_W)) ? BEAT_BW'(BE_W) : count[BEAT_BW-1:0];
endmodule

// File: rtl/ep_dma_pkt.sv
module ep_dma_pkt
  import ep_dma_pkg::*;
#(
  parameter int PKT_BYTES = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [BEAT_BW-1:0] beat_bytes,
  input  logic               last,
  input  logic               auto_en,
  input  logic               end_en,
  output logic               validate
);
  localparam int FW = $clog2(PKT_BYTES + 1);

  logic [FW-1:0] fill_q;
  logic [FW:0]   fill_sum;
  logic          full;

  assign fill_sum = {1'b0, fill_q} + (FW+1)'(beat_bytes);
  assign full     = fill_sum >= (FW+1)'(PKT_BYTES);
  assign validate = fire & ((full & auto_en) | (last & end_en));

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else if (fire) begin
      fill_q <= (full | validate) ? '0 : fill_sum[FW-1:0];
    end
  end
endmodule

// File: rtl/ep_dma_fsm.sv
module ep_dma_fsm
  import ep_dma_pkg::*;
#(
  parameter int PKT_BYTES  = 64,
  parameter int DESC_ALIGN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              ep_is_ctrl,
  input  logic              ep_auto_valid,
  input  logic              ep_irq,
  input  logic              bank_full,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ep_wr,
  output logic [DATA_W-1:0] ep_wdata,
  output logic [BE_W-1:0]   ep_be,
  output logic              ep_valid,
  output logic              irq,
  output logic              busy,
  output logic [DATA_W-1:0] next_view,
  output logic [DATA_W-1:0] buf_view,
  output logic [DATA_W-1:0] ctrl_view,
  output logic [DATA_W-1:0] stat_view
);
  localparam int WA = $clog2(BE_W);

  state_e             st;
  ctrl_t              ctrl_q;
  logic [DATA_W-1:0]  next_q, buf_q, data_q;
  logic [CNT_W-1:0]   rem_q;
  logic               eob_q, eot_q;
  logic [1:0]         fidx;
  logic [BEAT_BW-1:0] beat_bytes;
  logic [BE_W-1:0]    lane_be;
  logic               fire, last, validate, abort_req;

  ep_dma_beat #(.CW(CNT_W)) u_beat (
    .count      (ctrl_q.count),
    .beat_bytes (beat_bytes),
    .be         (lane_be)
  );

  assign fire      = (st == S_WRITE) && !bank_full;
  assign last      = ctrl_q.count == CNT_W'(beat_bytes);
  assign abort_req = ctrl_q.irq_stop & ep_irq;

  ep_dma_pkt #(.PKT_BYTES(PKT_BYTES)) u_pkt (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .beat_bytes (beat_bytes),
    .last       (last),
    .auto_en    (ep_auto_valid),
    .end_en     (ctrl_q.end_valid),
    .validate   (validate)
  );

  assign busy      = st != S_IDLE;
  assign next_view = next_q;
  assign buf_view  = buf_q;
  assign ctrl_view = ctrl_q;
  assign stat_view = {rem_q, 13'd0, eot_q, eob_q, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      ctrl_q   <= '0;
      next_q   <= '0;
      buf_q    <= '0;
      data_q   <= '0;
      rem_q    <= '0;
      eob_q    <= 1'b0;
      eot_q    <= 1'b0;
      fidx     <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      ep_wr    <= 1'b0;
      ep_wdata <= '0;
      ep_be    <= '0;
      ep_valid <= 1'b0;
      irq      <= 1'b0;
    end else begin
      ep_wr    <= 1'b0;
      ep_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (reg_wr) begin
            case (reg_addr)
              REG_NEXT: next_q <= {reg_wdata[DATA_W-1:DESC_ALIGN], DESC_ALIGN'(0)};
              REG_BUF:  buf_q  <= {reg_wdata[DATA_W-1:WA], WA'(0)};
              REG_CTRL: begin
                ctrl_q <= ctrl_t'(reg_wdata);
                if (ep_is_ctrl) ctrl_q.enable <= 1'b0;
                eob_q <= 1'b0;
                eot_q <= 1'b0;
                irq   <= 1'b0;
              end
              default: ;
            endcase
          end else if (ctrl_q.enable) begin
            if (ctrl_q.load_next) begin
              st       <= S_FETCH;
              fidx     <= '0;
              mem_req  <= 1'b1;
              mem_addr <= next_q;
            end else begin
              st <= S_BEAT;
            end
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            case (fidx)
              2'd0:    next_q <= {mem_rdata[DATA_W-1:DESC_ALIGN], DESC_ALIGN'(0)};
              2'd1:    buf_q  <= {mem_rdata[DATA_W-1:WA], WA'(0)};
              default: ctrl_q <= ctrl_t'(mem_rdata);
            endcase
            if (fidx == 2'd2) begin
              mem_req <= 1'b0;
              st      <= mem_rdata[0] ? S_BEAT : S_IDLE;
            end else begin
              fidx     <= fidx + 2'd1;
              mem_addr <= mem_addr + DATA_W'(BE_W);
            end
          end
        end
        S_BEAT: begin
          if (ctrl_q.count == '0) begin
            rem_q <= '0;
            if (ctrl_q.eob_ie) begin
              eob_q <= 1'b1;
              irq   <= 1'b1;
            end
            if (ctrl_q.load_next) begin
              st       <= S_FETCH;
              fidx     <= '0;
              mem_req  <= 1'b1;
              mem_addr <= next_q;
            end else begin
              ctrl_q.enable <= 1'b0;
              st            <= S_IDLE;
            end
          end else if (abort_req) begin
            rem_q         <= ctrl_q.count;
            eot_q         <= 1'b1;
            irq           <= 1'b1;
            ctrl_q.enable <= 1'b0;
            st            <= S_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= buf_q;
            st       <= S_READ;
          end
        end
        S_READ: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            data_q  <= mem_rdata;
            st      <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (fire) begin
            ep_wr        <= 1'b1;
            ep_wdata     <= data_q;
            ep_be        <= lane_be;
            ep_valid     <= validate;
            ctrl_q.count <= ctrl_q.count - CNT_W'(beat_bytes);
            buf_q        <= buf_q + DATA_W'(BE_W);
            st           <= S_BEAT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ep_dma_chan.sv
module ep_dma_chan
  import ep_dma_pkg::*;
#(
  parameter int PKT_BYTES  = 64,
  parameter int DESC_ALIGN = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ep_is_ctrl,
  input  logic        ep_auto_valid,
  input  logic        ep_irq,
  input  logic        bank_full,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        ep_wr,
  output logic [31:0] ep_wdata,
  output logic [3:0]  ep_be,
  output logic        ep_valid,
  output logic        irq
);
  logic              chan_busy;
  logic [DATA_W-1:0] next_view, buf_view, ctrl_view, stat_view;

  ep_dma_fsm #(.PKT_BYTES(PKT_BYTES), .DESC_ALIGN(DESC_ALIGN)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .ep_is_ctrl    (ep_is_ctrl),
    .ep_auto_valid (ep_auto_valid),
    .ep_irq        (ep_irq),
    .bank_full     (bank_full),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .ep_wr         (ep_wr),
    .ep_wdata      (ep_wdata),
    .ep_be         (ep_be),
    .ep_valid      (ep_valid),
    .irq           (irq),
    .busy          (chan_busy),
    .next_view     (next_view),
    .buf_view      (buf_view),
    .ctrl_view     (ctrl_view),
    .stat_view     (stat_view)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        REG_NEXT: reg_rdata <= next_view;
        REG_BUF:  reg_rdata <= buf_view;
        REG_CTRL: reg_rdata <= ctrl_view;
        default:  reg_rdata <= stat_view;
      endcase
    end
  end
endmodule

// File: rtl/ep_dma_chan_chk.sv
module ep_dma_chan_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       ep_is_ctrl,
  input logic       bank_full,
  input logic       mem_req,
  input logic       mem_ack,
  input logic       ep_wr,
  input logic [3:0] ep_be,
  input logic       ep_valid,
  input logic       irq,
  input logic       chan_busy
);
  p_no_req_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !chan_busy |-> !mem_req);

  p_ctrl_ep_stays_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd2 && ep_is_ctrl && !chan_busy) |=> ##1 !chan_busy);

  p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req);

  p_be_contiguous_r4: assert property (@(posedge clk) disable iff (rst)
    ep_wr |-> (ep_be == 4'b0001 || ep_be == 4'b0011 || ep_be == 4'b0111 || ep_be == 4'b1111));

  p_no_write_when_full_r5: assert property (@(posedge clk) disable iff (rst)
    ep_wr |-> !$past(bank_full));

  p_valid_with_write_r7: assert property (@(posedge clk) disable iff (rst)
    ep_valid |-> ep_wr);

  p_irq_cleared_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd2 && !chan_busy) |=> !irq);
endmodule

bind ep_dma_chan ep_dma_chan_chk u_chk (.*);

// File: tb/ep_dma_chan_tb.sv
`timescale 1ns/1ps
module ep_dma_chan_tb;
  localparam int PKT = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ep_is_ctrl = 1'b0;
  logic        ep_auto_valid = 1'b0;
  logic        ep_irq = 1'b0;
  logic        bank_full = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        ep_wr;
  logic [31:0] ep_wdata;
  logic [3:0]  ep_be;
  logic        ep_valid;
  logic        irq;

  ep_dma_chan #(.PKT_BYTES(PKT)) u_dut (.*);

  always #4 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [36:0] exp_q[$];
  int          checks = 0, errors = 0, cyc = 0, fill = 0;
  int          req_seen = 0, wr_count = 0, abort_after = 0, stall_mode = 0;
  bit          bank_prev = 1'b0, done = 1'b0;
  string       cur_tag = "R3";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder: acknowledges one cycle after a request is seen
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      mem_rdata = mem[mem_addr[11:2]];
    end else begin
      mem_ack = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (stall_mode == 1) bank_full = 1'($urandom_range(0, 1));
    else if (stall_mode == 2) bank_full = 1'b1;
    else bank_full = 1'b0;
  end

  always @(posedge clk) bank_prev <= bank_full;

  // per-clock monitor against the reference queue
  always @(negedge clk) begin
    if (mem_req) req_seen++;
    if (abort_after == 0) ep_irq = 1'b0;
    if (ep_wr) begin
      wr_count++;
      chk("R5", {31'd0, bank_prev}, 32'd0);
      if (exp_q.size() == 0) begin
        chk(cur_tag, ep_wdata, 32'hXXXX_XXXE);
      end else begin
        logic [36:0] e;
        e = exp_q.pop_front();
        chk(cur_tag, ep_wdata, e[31:0]);
        chk("R4", {28'd0, ep_be}, {28'd0, e[35:32]});
        chk("R7", {31'd0, ep_valid}, {31'd0, e[36]});
      end
      if (abort_after != 0 && wr_count == abort_after) ep_irq = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // reference: expected word stream for one buffer
  task automatic model_buf(input logic [31:0] a0, input int cnt, input bit auto_v,
                           input bit endv, input int limit);
    int rem = cnt;
    int n = 0;
    logic [31:0] a = {a0[31:2], 2'b00};
    while (rem > 0 && (limit == 0 || n < limit)) begin
      int b = (rem >= 4) ? 4 : rem;
      bit full, lastw, v;
      logic [3:0] be = 4'((1 << b) - 1);
      fill += b;
      full = fill >= PKT;
      lastw = (rem - b) == 0;
      v = (full && auto_v) || (lastw && endv);
      if (full || v) fill = 0;
      exp_q.push_back({v, be, mem[a[11:2]]});
      a += 4;
      rem -= b;
      n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    fill = 0;
    exp_q.delete();
    req_seen = 0;
    wr_count = 0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk) reg_addr = a;
    @(negedge clk) d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5000; i++) begin
      rd_reg(2'd3, s);
      if (!s[0]) break;
    end
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = {16'(i) ^ 16'h5A5A, 16'(i) + 16'h1000};
    // descriptor chain at 0x800 and 0x840
    mem[10'h200] = 32'h0000_0847;
    mem[10'h201] = 32'h0000_0400;
    mem[10'h202] = {16'd6, 16'h000F};
    mem[10'h210] = 32'h0000_0000;
    mem[10'h211] = 32'h0000_0503;
    mem[10'h212] = {16'd5, 16'h000D};

    // R1 reset state
    do_reset();
    for (int r = 0; r < 4; r++) begin
      rd_reg(2'(r), v);
      chk("R1", v, 32'd0);
    end
    chk("R1", {29'd0, mem_req, ep_wr, irq}, 32'd0);

    // R2 control endpoint refuses to start
    ep_is_ctrl = 1'b1;
    wr_reg(2'd1, 32'h0000_0100);
    wr_reg(2'd2, {16'd8, 16'h0001});
    repeat (10) @(negedge clk);
    chk("R2", req_seen, 0);
    rd_reg(2'd2, v); chk("R2", v, {16'd8, 16'h0000});
    rd_reg(2'd3, v); chk("R2", v, 32'd0);
    ep_is_ctrl = 1'b0;

    // R3 R4 R7 R9: 11-byte buffer, unaligned start, short last word
    do_reset();
    cur_tag = "R3";
    ep_auto_valid = 1'b1;
    wr_reg(2'd1, 32'h0000_0103);
    model_buf(32'h100, 11, 1'b1, 1'b1, 0);
    wr_reg(2'd2, {16'd11, 16'h000D});
    wait_idle();
    chk("R3", exp_q.size(), 0);
    rd_reg(2'd3, v); chk("R9", v, 32'h0000_0002);
    rd_reg(2'd2, v); chk("R9", v, 32'h0000_000C);
    rd_reg(2'd1, v); chk("R3", v, 32'h0000_010C);
    chk("R9", {31'd0, irq}, 32'd1);
    // R12 control write clears flags
    wr_reg(2'd2, 32'd0);
    @(negedge clk);
    chk("R12", {31'd0, irq}, 32'd0);
    rd_reg(2'd3, v); chk("R12", v, 32'd0);

    // R5 R6: random bank-full stalls, auto validation on full packets
    do_reset();
    cur_tag = "R6";
    stall_mode = 1;
    wr_reg(2'd1, 32'h0000_0200);
    model_buf(32'h200, 40, 1'b1, 1'b0, 0);
    wr_reg(2'd2, {16'd40, 16'h0001});
    wait_idle();
    stall_mode = 0;
    chk("R5", exp_q.size(), 0);
    chk("R6", wr_count, 10);
    rd_reg(2'd3, v); chk("R9", v, 32'd0);
    chk("R9", {31'd0, irq}, 32'd0);

    // R8 descriptor chain
    do_reset();
    cur_tag = "R8";
    ep_auto_valid = 1'b0;
    wr_reg(2'd0, 32'h0000_0805);
    rd_reg(2'd0, v); chk("R8", v, 32'h0000_0800);
    model_buf(32'h400, 6, 1'b0, 1'b1, 0);
    model_buf(32'h500, 5, 1'b0, 1'b1, 0);
    wr_reg(2'd2, 32'h0000_0003);
    wait_idle();
    chk("R8", exp_q.size(), 0);
    rd_reg(2'd0, v); chk("R8", v, 32'h0000_0000);
    rd_reg(2'd1, v); chk("R8", v, 32'h0000_0508);
    rd_reg(2'd2, v); chk("R9", v, 32'h0000_000C);
    rd_reg(2'd3, v); chk("R9", v, 32'h0000_0002);

    // R10 abort after three words
    do_reset();
    cur_tag = "R10";
    abort_after = 3;
    wr_reg(2'd1, 32'h0000_0600);
    model_buf(32'h600, 64, 1'b0, 1'b0, 3);
    wr_reg(2'd2, {16'd64, 16'h0011});
    wait_idle();
    repeat (20) @(negedge clk);
    abort_after = 0;
    chk("R10", exp_q.size(), 0);
    chk("R10", wr_count, 3);
    rd_reg(2'd3, v); chk("R10", v, {16'd52, 16'h0004});
    rd_reg(2'd2, v); chk("R10", v, {16'd52, 16'h0010});
    chk("R10", {31'd0, irq}, 32'd1);

    // R11 writes while busy are ignored
    do_reset();
    cur_tag = "R11";
    stall_mode = 2;
    wr_reg(2'd1, 32'h0000_0700);
    model_buf(32'h700, 16, 1'b0, 1'b0, 0);
    wr_reg(2'd2, {16'd16, 16'h0001});
    repeat (10) @(negedge clk);
    wr_reg(2'd0, 32'h0000_7770);
    wr_reg(2'd2, 32'd0);
    wr_reg(2'd1, 32'h0000_0040);
    rd_reg(2'd3, v); chk("R11", {31'd0, v[0]}, 32'd1);
    stall_mode = 0;
    wait_idle();
    chk("R11", exp_q.size(), 0);
    rd_reg(2'd0, v); chk("R11", v, 32'd0);
    rd_reg(2'd1, v); chk("R11", v, 32'h0000_0710);
    rd_reg(2'd2, v); chk("R11", v, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule